// File: doc/BRIEF.md
# Serial Control Register Port

This block is the host-facing register port of a four-channel line codec. A host talks to it over four wires: an active-low select, a serial clock, serial data in and a serial data out that is only driven on read cycles. Every transfer is eight bits, most significant bit first. The host writes a configuration byte, marked by a leading 1, which chooses the target of the following data byte. A data byte, marked by a leading 0, then lands in one of these targets: a time-slot register, a signalling-control register or one half of a gain coefficient. Which one depends on the stored configuration.

The block drives five signalling lines per channel. Three are always outputs. Two have a direction set per channel. The block also builds a status byte from those lines. In signalling mode, a data write returns the status byte of the same channel on the same transfer. A command-driven status-fetch procedure lets data in and data out share one wire. The three serial inputs are synchronised into the system clock and their edges are detected there. The signalling input lines are taken as already synchronous to the system clock. Gain arithmetic and the PCM datapath lie outside this block.

Top module: `sci_regport`

## Requirements
- R1: After reset: A-law selected (`law_alaw`=1), delay timing (`delay_mode`=1), all channels powered down, all slot, gain and signalling-control registers zero, every bidirectional signalling line an input (`sig_io_oe`=0), and `sdo_en`=0.
- R2: A completed 8-bit transfer whose first bit is 1, other than the three command codes, stores bits 6:0 as the configuration. Bits 6:5 give the mode (00 µ-law codec, 01 A-law codec, 10 signalling/gain, 11 reserved) and bits 3:2 give the channel. In codec modes, bit 5 is copied to `law_alaw`.
- R3: A configuration write with bit 6 = 0 sets `delay_mode` from bit 4. It also sets the power of the addressed channel from bits 1:0: bit 1 is transmit (`tx_pwr`) and bit 0 is receive (`rx_pwr`).
- R4: In codec mode, a data byte (first bit 0) writes its bits 6:0 to the receive slot of the addressed channel if configuration bit 0 is 1, and to the transmit slot if configuration bit 1 is 1. With bits 1:0 = 00 it writes nothing.
- R5: A configuration write with bits 6:4 = 101 sets the directions of the addressed channel from bits 1:0. Bit 1 is line I/O_1 and bit 0 is line I/O_0, and a 1 makes the line an input (`sig_io_oe` low).
- R6: With configuration bits 6:4 = 101, a data byte stores bits 4:0 into the addressed channel's control register. Bits 4:2 drive `sig_o` (channel c: bit 3c+2 = O_4, 3c+1 = O_3, 3c = O_2). Bits 1:0 drive `sig_io_out` (bit 2c+1 = I/O_1, 2c = I/O_0).
- R7: In that mode, the same transfer shifts out the status byte, captured when select falls. From bit 7 down, its bits are I/O_0, I/O_1, O_2, O_3, O_4 of the addressed channel, then the I/O_0 line of channels 1, 2 and 3. A line's value is its input pin when it is an input and its driven value otherwise. `sdo` changes after rising serial-clock edges, and inputs are taken on falling edges.
- R8: With configuration bits 6:4 = 100, a data byte writes its bits 6:0 into one half of the addressed channel's 14-bit gain coefficient. Configuration bit 1 selects transmit (1) or receive (0). Bit 0 selects the upper half, bits 13:7 (1), or the lower half, bits 6:0 (0).
- R9: With configuration bits 6:5 = 11, a data byte changes no register.
- R10: A transfer that ends with fewer or more than 8 falling serial-clock edges changes no register.
- R11: `sdo_en` is low whenever select is high. It is high only during read transfers.
- R12: Command 0xFE enters fetch mode and 0xFD leaves it. In fetch mode, writes in signalling mode no longer drive `sdo`. Instead, 0xFF issued with signalling mode selected makes the next transfer a read-only status cycle, during which the input bits are ignored. The three command codes never alter the configuration, and 0xFF has no effect outside fetch mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| csn | input | 1 | Active-low transfer select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_en | output | 1 | Drive enable for `sdo` |
| law_alaw | output | 1 | 1 = A-law, 0 = µ-law |
| delay_mode | output | 1 | 1 = delayed frame timing |
| tx_pwr | output | 4 | Transmit power per channel |
| rx_pwr | output | 4 | Receive power per channel |
| tx_slot | output | 28 | Transmit slot, 7 bits per channel |
| rx_slot | output | 28 | Receive slot, 7 bits per channel |
| gain_tx | output | 56 | Transmit gain coefficient, 14 bits per channel |
| gain_rx | output | 56 | Receive gain coefficient, 14 bits per channel |
| sig_o | output | 12 | Output-only signalling lines |
| sig_io_in | input | 8 | Bidirectional signalling lines, pin value |
| sig_io_out | output | 8 | Bidirectional signalling lines, driven value |
| sig_io_oe | output | 8 | Bidirectional signalling lines, drive enable |

## Verification
Each register result lands on the third system-clock edge after select rises: two synchroniser stages, then the edge detector feeding the commit. Each `sdo` bit appears on the third edge after the serial clock rises. `sdo_en` follows select within three edges. The bench's behavioural model updates its expected registers on exactly that third edge after raising select. It compares every output on each falling system-clock edge, and checks `sdo_en` only once select has been steady for four cycles. Each status bit is sampled eight cycles after the serial clock rises, just before the falling serial edge on which a host would sample it.

// File: rtl/sci_pkg.sv
package sci_pkg;
  localparam logic [7:0] CMD_ENTER = 8'hFE;
  localparam logic [7:0] CMD_LEAVE = 8'hFD;
  localparam logic [7:0] CMD_FETCH = 8'hFF;
  localparam logic [2:0] SEL_SIG   = 3'b101;
  localparam logic [2:0] SEL_GAIN  = 3'b100;
  localparam logic [6:0] CFG_RESET = 7'b011_0000;
endpackage

// File: rtl/sci_sync.sv
module sci_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/sci_shifter.sv
module sci_shifter #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              csn_s,
  input  logic              sdi_s,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              drive_req,
  output logic              start,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sdo,
  output logic              sdo_en
);
  logic              sck_d, csn_d;
  logic              rise_sck, fall_sck, cs_rise;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] rxsh_q, rxsh_d, txsh_q, txsh_d;
  logic              sdo_q, sdo_d, drv_q, drv_d;

  assign rise_sck = ~sck_d & sck_s & ~csn_s;
  assign fall_sck = sck_d & ~sck_s & ~csn_s;
  assign start    = csn_d & ~csn_s;
  assign cs_rise  = ~csn_d & csn_s;
  assign done     = cs_rise && (cnt_q == CNT_W'(BYTE_W));
  assign rx_byte  = rxsh_q;
  assign sdo      = sdo_q;
  assign sdo_en   = drv_q & ~csn_s;

  always_comb begin
    cnt_d  = cnt_q;
    rxsh_d = rxsh_q;
    txsh_d = txsh_q;
    sdo_d  = sdo_q;
    drv_d  = drv_q;
    if (start) begin
      cnt_d  = '0;
      txsh_d = load_byte;
      drv_d  = drive_req;
    end
    if (fall_sck) begin
      rxsh_d = {rxsh_q[BYTE_W-2:0], sdi_s};
      if (cnt_q != CNT_W'(BYTE_W + 1)) cnt_d = cnt_q + 1'b1;
    end
    if (rise_sck) begin
      sdo_d  = txsh_q[BYTE_W-1];
      txsh_d = {txsh_q[BYTE_W-2:0], 1'b0};
    end
    if (cs_rise) drv_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d  <= 1'b0;
      csn_d  <= 1'b1;
      cnt_q  <= '0;
      rxsh_q <= '0;
      txsh_q <= '0;
      sdo_q  <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      sck_d  <= sck_s;
      csn_d  <= csn_s;
      cnt_q  <= cnt_d;
      rxsh_q <= rxsh_d;
      txsh_q <= txsh_d;
      sdo_q  <= sdo_d;
      drv_q  <= drv_d;
    end
  end

  // R7: the output bit moves only on a detected rising serial edge
  p_sdo_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_sck |=> $stable(sdo_q));
endmodule

// File: rtl/sci_regfile.sv
module sci_regfile import sci_pkg::*; #(
  parameter int NCH    = 4,
  parameter int SLOT_W = 7,
  parameter int HALF_W = 7,
  localparam int CH_W   = $clog2(NCH),
  localparam int GAIN_W = 2 * HALF_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          done,
  input  logic [7:0]                    rx_byte,
  output logic [CH_W-1:0]               chan,
  output logic                          law_a,
  output logic                          delay_md,
  output logic [NCH-1:0][1:0]           pwr,
  output logic [NCH-1:0][SLOT_W-1:0]    txs,
  output logic [NCH-1:0][SLOT_W-1:0]    rxs,
  output logic [NCH-1:0][4:0]           ctrl,
  output logic [NCH-1:0][1:0]           dir_in,
  output logic [NCH-1:0][GAIN_W-1:0]    gtx,
  output logic [NCH-1:0][GAIN_W-1:0]    grx,
  output logic                          drive_req
);
  logic [6:0]                   cr_q, cr_d;
  logic                         law_q, law_d, dly_q, dly_d;
  logic [NCH-1:0][1:0]          pwr_q, pwr_d, dir_q, dir_d;
  logic [NCH-1:0][SLOT_W-1:0]   txs_q, txs_d, rxs_q, rxs_d;
  logic [NCH-1:0][4:0]          ctrl_q, ctrl_d;
  logic [NCH-1:0][GAIN_W-1:0]   gtx_q, gtx_d, grx_q, grx_d;
  logic                         stream_q, stream_d, armed_q, armed_d, fetch_q, fetch_d;
  logic [CH_W-1:0]              bch;

  assign chan      = cr_q[2 +: CH_W];
  assign bch       = rx_byte[2 +: CH_W];
  assign drive_req = stream_q ? armed_q : (cr_q[6:4] == SEL_SIG);
  assign law_a     = law_q;
  assign delay_md  = dly_q;
  assign pwr       = pwr_q;
  assign txs       = txs_q;
  assign rxs       = rxs_q;
  assign ctrl      = ctrl_q;
  assign dir_in    = dir_q;
  assign gtx       = gtx_q;
  assign grx       = grx_q;

  always_comb begin
    cr_d = cr_q;   law_d = law_q;   dly_d = dly_q;   pwr_d = pwr_q;
    txs_d = txs_q; rxs_d = rxs_q;   ctrl_d = ctrl_q; dir_d = dir_q;
    gtx_d = gtx_q; grx_d = grx_q;
    stream_d = stream_q; armed_d = armed_q; fetch_d = fetch_q;
    if (start) begin
      fetch_d = armed_q;
      armed_d = 1'b0;
    end
    if (done && !fetch_q) begin
      if (rx_byte[7]) begin
        if (rx_byte == CMD_ENTER) stream_d = 1'b1;
        else if (rx_byte == CMD_LEAVE) begin
          stream_d = 1'b0;
          armed_d  = 1'b0;
        end else if (rx_byte == CMD_FETCH) begin
          if (stream_q && cr_q[6:4] == SEL_SIG) armed_d = 1'b1;
        end else begin
          cr_d = rx_byte[6:0];
          if (!rx_byte[6]) begin
            law_d      = rx_byte[5];
            dly_d      = rx_byte[4];
            pwr_d[bch] = rx_byte[1:0];
          end else if (rx_byte[5:4] == 2'b01) begin
            dir_d[bch] = rx_byte[1:0];
          end
        end
      end else begin
        if (!cr_q[6]) begin
          if (cr_q[0]) rxs_d[chan] = rx_byte[SLOT_W-1:0];
          if (cr_q[1]) txs_d[chan] = rx_byte[SLOT_W-1:0];
        end else if (cr_q[5:4] == 2'b01) begin
          ctrl_d[chan] = rx_byte[4:0];
        end else if (cr_q[5:4] == 2'b00) begin
          if (cr_q[1]) begin
            if (cr_q[0]) gtx_d[chan][HALF_W +: HALF_W] = rx_byte[HALF_W-1:0];
            else         gtx_d[chan][0 +: HALF_W]      = rx_byte[HALF_W-1:0];
          end else begin
            if (cr_q[0]) grx_d[chan][HALF_W +: HALF_W] = rx_byte[HALF_W-1:0];
            else         grx_d[chan][0 +: HALF_W]      = rx_byte[HALF_W-1:0];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q <= CFG_RESET;  law_q <= 1'b1;  dly_q <= 1'b1;  pwr_q <= '0;
      txs_q <= '0;        rxs_q <= '0;    ctrl_q <= '0;   dir_q <= '1;
      gtx_q <= '0;        grx_q <= '0;
      stream_q <= 1'b0;   armed_q <= 1'b0; fetch_q <= 1'b0;
    end else begin
      cr_q <= cr_d;       law_q <= law_d; dly_q <= dly_d; pwr_q <= pwr_d;
      txs_q <= txs_d;     rxs_q <= rxs_d; ctrl_q <= ctrl_d; dir_q <= dir_d;
      gtx_q <= gtx_d;     grx_q <= grx_d;
      stream_q <= stream_d; armed_q <= armed_d; fetch_q <= fetch_d;
    end
  end

  // R9: reserved mode never lets a data byte land anywhere
  p_reserved_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fetch_q && !rx_byte[7] && cr_q[6:5] == 2'b11)
    |=> ($stable(ctrl_q) && $stable(txs_q) && $stable(rxs_q) && $stable(gtx_q) && $stable(grx_q)));
  // R10: without a completed 8-bit transfer no register moves
  p_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(cr_q) && $stable(ctrl_q) && $stable(txs_q) && $stable(rxs_q)
               && $stable(gtx_q) && $stable(grx_q) && $stable(dir_q) && $stable(pwr_q)));
  // R12: command codes leave the configuration untouched
  p_cmd_keeps_cfg_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_byte[7:2] == 6'b111111 && rx_byte[1:0] != 2'b00) |=> $stable(cr_q));
  // R12: a fetch cycle is read-only
  p_fetch_readonly_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fetch_q) |=> ($stable(ctrl_q) && $stable(cr_q)));
endmodule

// File: rtl/sci_regport.sv
module sci_regport #(
  parameter int NCH    = 4,
  parameter int SLOT_W = 7,
  parameter int HALF_W = 7,
  localparam int CH_W   = $clog2(NCH),
  localparam int GAIN_W = 2 * HALF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sck,
  input  logic                    csn,
  input  logic                    sdi,
  output logic                    sdo,
  output logic                    sdo_en,
  output logic                    law_alaw,
  output logic                    delay_mode,
  output logic [NCH-1:0]          tx_pwr,
  output logic [NCH-1:0]          rx_pwr,
  output logic [NCH*SLOT_W-1:0]   tx_slot,
  output logic [NCH*SLOT_W-1:0]   rx_slot,
  output logic [NCH*GAIN_W-1:0]   gain_tx,
  output logic [NCH*GAIN_W-1:0]   gain_rx,
  output logic [3*NCH-1:0]        sig_o,
  input  logic [2*NCH-1:0]        sig_io_in,
  output logic [2*NCH-1:0]        sig_io_out,
  output logic [2*NCH-1:0]        sig_io_oe
);
  logic                       sck_s, csn_s, sdi_s;
  logic                       start, done, drive_req;
  logic [7:0]                 rx_byte, status;
  logic [CH_W-1:0]            chan;
  logic [NCH-1:0][1:0]        pwr, dir_in, img;
  logic [NCH-1:0][SLOT_W-1:0] txs, rxs;
  logic [NCH-1:0][4:0]        ctrl;
  logic [NCH-1:0][GAIN_W-1:0] gtx, grx;

  sci_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck, csn, sdi}), .q({sck_s, csn_s, sdi_s}));

  sci_shifter #(.BYTE_W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .csn_s(csn_s), .sdi_s(sdi_s),
    .load_byte(status), .drive_req(drive_req), .start(start), .done(done),
    .rx_byte(rx_byte), .sdo(sdo), .sdo_en(sdo_en));

  sci_regfile #(.NCH(NCH), .SLOT_W(SLOT_W), .HALF_W(HALF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .rx_byte(rx_byte),
    .chan(chan), .law_a(law_alaw), .delay_md(delay_mode), .pwr(pwr),
    .txs(txs), .rxs(rxs), .ctrl(ctrl), .dir_in(dir_in), .gtx(gtx), .grx(grx),
    .drive_req(drive_req));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign img[c] = (dir_in[c] & sig_io_in[2*c +: 2]) | (~dir_in[c] & ctrl[c][1:0]);
    assign sig_io_out[2*c +: 2] = ctrl[c][1:0];
    assign sig_io_oe[2*c +: 2]  = ~dir_in[c];
    assign sig_o[3*c +: 3]      = ctrl[c][4:2];
    assign tx_pwr[c]            = pwr[c][1];
    assign rx_pwr[c]            = pwr[c][0];
  end

  assign status  = {img[chan][0], img[chan][1], ctrl[chan][2], ctrl[chan][3], ctrl[chan][4],
                    img[1][0], img[2][0], img[3][0]};
  assign tx_slot = txs;
  assign rx_slot = rxs;
  assign gain_tx = gtx;
  assign gain_rx = grx;

  // R11: three idle cycles of select guarantee a released data wire
  p_hiz_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (csn && $past(csn) && $past(csn, 2)) |-> !sdo_en);
endmodule

// File: tb/sci_regport_tb_top.sv
module sci_regport_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic [7:0] io_in = 8'h00;
  logic sdo, sdo_en, law_alaw, delay_mode;
  logic [3:0] tx_pwr, rx_pwr;
  logic [27:0] tx_slot, rx_slot;
  logic [55:0] gain_tx, gain_rx;
  logic [11:0] sig_o;
  logic [7:0] sig_io_out, sig_io_oe;

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural model state
  logic [6:0]       m_cr = 7'b011_0000;
  logic             m_law = 1, m_dly = 1, m_stream = 0, m_armed = 0, m_fetch = 0, exp_rd = 0;
  logic [3:0][1:0]  m_pwr = '0, m_dir = '1;
  logic [3:0][6:0]  m_txs = '0, m_rxs = '0;
  logic [3:0][4:0]  m_ctrl = '0;
  logic [3:0][13:0] m_gtx = '0, m_grx = '0;
  logic             csn_prev = 1;
  int               cs_stable = 0;

  always #10 clk = ~clk;

  sci_regport dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en),
    .law_alaw(law_alaw), .delay_mode(delay_mode), .tx_pwr(tx_pwr), .rx_pwr(rx_pwr),
    .tx_slot(tx_slot), .rx_slot(rx_slot), .gain_tx(gain_tx), .gain_rx(gain_rx),
    .sig_o(sig_o), .sig_io_in(io_in), .sig_io_out(sig_io_out), .sig_io_oe(sig_io_oe));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  function automatic logic [7:0] exp_status();
    logic [1:0] ch;
    logic [3:0][1:0] im;
    ch = m_cr[3:2];
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 2; b++)
        im[c][b] = m_dir[c][b] ? io_in[2*c+b] : m_ctrl[c][b];
    return {im[ch][0], im[ch][1], m_ctrl[ch][2], m_ctrl[ch][3], m_ctrl[ch][4],
            im[1][0], im[2][0], im[3][0]};
  endfunction

  task automatic commit(input logic [7:0] b);
    logic [1:0] ch;
    ch = m_cr[3:2];
    if (m_fetch) return;
    if (b[7]) begin
      if (b == 8'hFE) m_stream = 1;
      else if (b == 8'hFD) begin m_stream = 0; m_armed = 0; end
      else if (b == 8'hFF) begin if (m_stream && m_cr[6:4] == 3'b101) m_armed = 1; end
      else begin
        m_cr = b[6:0];
        if (!b[6]) begin m_law = b[5]; m_dly = b[4]; m_pwr[b[3:2]] = b[1:0]; end
        else if (b[5:4] == 2'b01) m_dir[b[3:2]] = b[1:0];
      end
    end else if (!m_cr[6]) begin
      if (m_cr[0]) m_rxs[ch] = b[6:0];
      if (m_cr[1]) m_txs[ch] = b[6:0];
    end else if (m_cr[5:4] == 2'b01) m_ctrl[ch] = b[4:0];
    else if (m_cr[5:4] == 2'b00) begin
      if (m_cr[1]) begin if (m_cr[0]) m_gtx[ch][13:7] = b[6:0]; else m_gtx[ch][6:0] = b[6:0]; end
      else begin if (m_cr[0]) m_grx[ch][13:7] = b[6:0]; else m_grx[ch][6:0] = b[6:0]; end
    end
  endtask

  task automatic xfer(input logic [7:0] b, input int nb, input string tag);
    logic [7:0] got, st;
    logic rd;
    got = 8'h00;
    st  = exp_status();
    rd  = m_stream ? m_armed : (m_cr[6:4] == 3'b101);
    m_fetch = m_armed; m_armed = 0; exp_rd = rd;
    csn = 0; step(8);
    for (int i = 0; i < nb; i++) begin
      sck = 1; sdi = (i < 8) ? b[7-i] : 1'b0; step(8);
      if (i < 8) got[7-i] = sdo;
      sck = 0; step(8);
    end
    csn = 1; exp_rd = 0;
    repeat (3) @(posedge clk);
    if (nb == 8) commit(b);
    step(6);
    if (rd && nb == 8) chk(tag, {56'h0, got}, {56'h0, st});
  endtask

  // reference comparison on every falling clock edge
  always @(negedge clk) begin
    if (csn !== csn_prev) cs_stable = 0; else cs_stable++;
    csn_prev = csn;
    if (rst_n && !finished) begin
      chk("R2 law", {63'h0, law_alaw}, {63'h0, m_law});
      chk("R3 timing/power", {54'h0, delay_mode, tx_pwr, rx_pwr},
          {54'h0, m_dly, m_pwr[3][1], m_pwr[2][1], m_pwr[1][1], m_pwr[0][1],
           m_pwr[3][0], m_pwr[2][0], m_pwr[1][0], m_pwr[0][0]});
      chk("R4 slots", {8'h0, tx_slot, rx_slot}, {8'h0, m_txs, m_rxs});
      chk("R5 directions", {56'h0, sig_io_oe}, {56'h0, ~m_dir});
      chk("R6 signalling out", {44'h0, sig_o, sig_io_out},
          {44'h0, m_ctrl[3][4:2], m_ctrl[2][4:2], m_ctrl[1][4:2], m_ctrl[0][4:2],
           m_ctrl[3][1:0], m_ctrl[2][1:0], m_ctrl[1][1:0], m_ctrl[0][1:0]});
      chk("R8 gain tx", {8'h0, gain_tx}, {8'h0, m_gtx});
      chk("R8 gain rx", {8'h0, gain_rx}, {8'h0, m_grx});
      if (cs_stable >= 4) chk("R11 sdo_en", {63'h0, sdo_en}, {63'h0, exp_rd});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(5);
    rst_n = 1;
    step(2);
    // R1 reset defaults
    chk("R1 law", {63'h0, law_alaw}, 64'h1);
    chk("R1 delay", {63'h0, delay_mode}, 64'h1);
    chk("R1 power", {56'h0, tx_pwr, rx_pwr}, 64'h0);
    chk("R1 slots", {8'h0, tx_slot | rx_slot}, 64'h0);
    chk("R1 gain", {8'h0, gain_tx | gain_rx}, 64'h0);
    chk("R1 io dir", {56'h0, sig_io_oe}, 64'h0);
    chk("R1 ctrl", {52'h0, sig_o, sig_io_out}, 64'h0);
    chk("R1 sdo_en", {63'h0, sdo_en}, 64'h0);
    // R2 R3 R4: mu-law, non-delay, ch2 both slots
    xfer(8'h8B, 8, "R2"); xfer(8'h05, 8, "R4");
    // A-law, delay, ch1 receive only, max slot
    xfer(8'hB5, 8, "R2"); xfer(8'h7F, 8, "R4");
    // ch3 powered down: data writes no slot
    xfer(8'hBC, 8, "R3"); xfer(8'h33, 8, "R4");
    // R5 R6 R7: signalling ch0, I/O_1 out, I/O_0 in
    io_in = 8'b1010_0101;
    xfer(8'hD1, 8, "R5");
    xfer(8'h1F, 8, "R7");
    xfer(8'h0A, 8, "R7");
    // signalling ch2, both outputs, status cross bits
    xfer(8'hD8, 8, "R5");
    xfer(8'h15, 8, "R7");
    io_in = 8'b0100_1010;
    xfer(8'h0E, 8, "R7");
    // R8 gain halves
    xfer(8'hCF, 8, "R8"); xfer(8'h55, 8, "R8");
    xfer(8'hCC, 8, "R8"); xfer(8'h2A, 8, "R8");
    xfer(8'hC2, 8, "R8"); xfer(8'h7E, 8, "R8");
    xfer(8'hC5, 8, "R8"); xfer(8'h01, 8, "R8");
    // R9 reserved mode
    xfer(8'hE4, 8, "R9"); xfer(8'h1F, 8, "R9");
    xfer(8'hF8, 8, "R9"); xfer(8'h7F, 8, "R9");
    // R10 short and long transfers
    xfer(8'h8B, 5, "R10"); xfer(8'h92, 9, "R10"); xfer(8'h00, 3, "R10");
    // R12 fetch procedure on ch1
    xfer(8'hFF, 8, "R12");
    xfer(8'hFE, 8, "R12");
    xfer(8'hD7, 8, "R12");
    xfer(8'h13, 8, "R12");
    io_in = 8'b0011_1100;
    xfer(8'hFF, 8, "R12");
    xfer(8'h00, 8, "R12");
    xfer(8'hFF, 8, "R12");
    xfer(8'h1F, 8, "R12");
    xfer(8'hFD, 8, "R12");
    xfer(8'h0C, 8, "R7");
    xfer(8'hFF, 8, "R12");
    xfer(8'h03, 8, "R7");
    step(10);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule